// File: doc/BRIEF.md
# ROM-driven bus write sequencer

This block plays back a boot table of register writes onto a bus. The table lives in a read-only memory outside the block. Each 48-bit entry holds a 16-bit bus address in its upper part and a 32-bit data word in its lower part. After a start pulse the sequencer reads the entries in order from memory word 0. For every entry it issues one single write on its Wishbone master port and waits for the slave's acknowledge before it moves on.

An entry with every bit set marks the end of the table. When the sequencer reads that entry it issues no bus cycle, raises a completion flag and stays finished until reset. The top four address bits choose the target peripheral. The sequencer passes them through unchanged, so one table can program several slaves.

Top module: `rom_bus_writer`

## Requirements
- R1: While reset is high and in the first cycle after it, cyc, stb and we are low, sel is 0, done is low and the memory address is 0.
- R2: Without a start pulse the block stays idle: no bus cycle is issued and the memory address stays 0.
- R3: Each non-terminator entry produces exactly one write, in table order, with wb_adr equal to entry bits [47:32] (bits [47:44] select the peripheral) and wb_dat equal to entry bits [31:0].
- R4: During every write, sel is 4'b1111 and we is high together with cyc.
- R5: cyc and stb stay high with address and data unchanged until ack is sampled high, and they drop in the cycle after that edge. A write with an acknowledge delay of d cycles holds cyc for d+2 cycles.
- R6: After each acknowledged write, cyc stays low for at least one cycle before the next write begins.
- R7: The memory address is 0 for the first entry and rises by exactly one after each acknowledged write, and at no other time. The memory returns data one cycle after the address is applied.
- R8: The all-ones entry issues no bus cycle and raises done, which stays high until reset while the address rests on the terminator's index.
- R9: A start pulse during a running sequence or after done is ignored: no restart, no extra write, and done and the address do not change.
- R10: Without an acknowledge the write is held indefinitely; there is no timeout.
- R11: An entry that differs from all ones in any single bit is an ordinary write and does not end the sequence.
- R12: A reset in the middle of a write returns the block to idle, and the next start replays the table from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the table walk when the block is idle |
| rom_addr | output | 16 | Word address into the table memory |
| rom_data | input | 48 | Table entry, valid one cycle after rom_addr |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Write enable |
| wb_sel_o | output | 4 | Byte lane select |
| wb_adr_o | output | 16 | Bus address |
| wb_dat_o | output | 32 | Bus write data |
| wb_ack_i | input | 1 | Slave acknowledge |
| done | output | 1 | Table finished |

## Verification
The properties assume that the slave raises ack only while a cycle is open, and for one cycle at a time. They also assume that the memory presents the addressed word exactly one cycle after the address changes. The bench keeps to these conditions. Its memory model is a registered lookup of a constant table. Its slave model registers ack after a per-entry delay, holds it for one cycle only, and raises it only while cyc and stb are high. To cover the stall case, the bench withholds ack altogether and never raises it on its own.

// File: rtl/rbw_pkg.sv
package rbw_pkg;

  // Sequencer phases: address settle, entry load, bus write, finished.
  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_FETCH = 3'd1,
    SQ_LOAD  = 3'd2,
    SQ_WRITE = 3'd3,
    SQ_DONE  = 3'd4
  } seq_state_e;

endpackage

// File: rtl/rbw_entry_split.sv
module rbw_entry_split #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int ENTRY_W = ADDR_W + DATA_W
) (
  input  logic [ENTRY_W-1:0] entry,
  output logic [ADDR_W-1:0]  bus_adr,
  output logic [DATA_W-1:0]  bus_dat,
  output logic               is_term
);

  // Address sits in the upper field, data in the lower field.
  assign bus_adr = entry[ENTRY_W-1:DATA_W];
  assign bus_dat = entry[DATA_W-1:0];
  // End marker: every bit of the entry set.
  assign is_term = &entry;

endmodule

// File: rtl/rbw_rom_ptr.sv
module rbw_rom_ptr #(
  parameter int ROM_AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step,
  output logic [ROM_AW-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ptr <= '0;
    end else if (step) begin
      ptr <= ptr + ROM_AW'(1);
    end
  end

endmodule

// File: rtl/rbw_bus_drive.sv
module rbw_bus_drive #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int SEL_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic              retire,
  input  logic [ADDR_W-1:0] adr_in,
  input  logic [DATA_W-1:0] dat_in,
  output logic              cyc,
  output logic              stb,
  output logic              we,
  output logic [SEL_W-1:0]  sel,
  output logic [ADDR_W-1:0] adr,
  output logic [DATA_W-1:0] dat
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc <= 1'b0;
      stb <= 1'b0;
      we  <= 1'b0;
      sel <= '0;
      adr <= '0;
      dat <= '0;
    end else if (issue) begin
      cyc <= 1'b1;
      stb <= 1'b1;
      we  <= 1'b1;
      sel <= '1;
      adr <= adr_in;
      dat <= dat_in;
    end else if (retire) begin
      cyc <= 1'b0;
      stb <= 1'b0;
      we  <= 1'b0;
      sel <= '0;
    end
  end

endmodule

// File: rtl/rom_bus_writer.sv
module rom_bus_writer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int ROM_AW = 16,
  localparam int ENTRY_W = ADDR_W + DATA_W,
  localparam int SEL_W = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  output logic [ROM_AW-1:0]  rom_addr,
  input  logic [ENTRY_W-1:0] rom_data,
  output logic               wb_cyc_o,
  output logic               wb_stb_o,
  output logic               wb_we_o,
  output logic [SEL_W-1:0]   wb_sel_o,
  output logic [ADDR_W-1:0]  wb_adr_o,
  output logic [DATA_W-1:0]  wb_dat_o,
  input  logic               wb_ack_i,
  output logic               done
);

  import rbw_pkg::*;

  seq_state_e        state_q;
  logic [ADDR_W-1:0] ent_adr;
  logic [DATA_W-1:0] ent_dat;
  logic              ent_term;
  logic              issue;
  logic              retire;
  logic              launch;

  rbw_entry_split #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_split (
    .entry   (rom_data),
    .bus_adr (ent_adr),
    .bus_dat (ent_dat),
    .is_term (ent_term)
  );

  // Only an idle sequencer accepts start; later pulses fall through.
  assign launch = (state_q == SQ_IDLE) && start;
  assign issue  = (state_q == SQ_LOAD) && !ent_term;
  assign retire = (state_q == SQ_WRITE) && wb_ack_i;

  rbw_rom_ptr #(.ROM_AW(ROM_AW)) u_ptr (
    .clk  (clk),
    .rst  (rst),
    .clr  (launch),
    .step (retire),
    .ptr  (rom_addr)
  );

  rbw_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk    (clk),
    .rst    (rst),
    .issue  (issue),
    .retire (retire),
    .adr_in (ent_adr),
    .dat_in (ent_dat),
    .cyc    (wb_cyc_o),
    .stb    (wb_stb_o),
    .we     (wb_we_o),
    .sel    (wb_sel_o),
    .adr    (wb_adr_o),
    .dat    (wb_dat_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      done    <= 1'b0;
    end else begin
      case (state_q)
        SQ_IDLE:  if (start) state_q <= SQ_FETCH;
        // Address is stable this cycle; memory registers it at the edge.
        SQ_FETCH: state_q <= SQ_LOAD;
        SQ_LOAD: begin
          if (ent_term) begin
            state_q <= SQ_DONE;
            done    <= 1'b1;
          end else begin
            state_q <= SQ_WRITE;
          end
        end
        // No timeout: the write stays open until acknowledged.
        SQ_WRITE: if (wb_ack_i) state_q <= SQ_FETCH;
        SQ_DONE:  state_q <= SQ_DONE;
        default:  state_q <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rbw_checker.sv
module rbw_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int ROM_AW = 16,
  localparam int SEL_W = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              wb_cyc_o,
  input logic              wb_stb_o,
  input logic              wb_we_o,
  input logic [SEL_W-1:0]  wb_sel_o,
  input logic [ADDR_W-1:0] wb_adr_o,
  input logic [DATA_W-1:0] wb_dat_o,
  input logic              wb_ack_i,
  input logic              done
);

  p_lanes_full_r4: assert property (@(posedge clk) disable iff (rst)
    wb_cyc_o |-> (wb_sel_o == {SEL_W{1'b1}}) && wb_we_o && wb_stb_o);

  p_hold_until_ack_r5: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc_o && !wb_ack_i) |=> wb_cyc_o && $stable(wb_adr_o) && $stable(wb_dat_o));

  p_drop_after_ack_r5: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc_o && wb_ack_i) |=> !wb_cyc_o && !wb_stb_o);

  p_idle_gap_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(wb_cyc_o) |=> !wb_cyc_o);

  p_addr_step_r7: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc_o && wb_ack_i) |=> rom_addr == $past(rom_addr) + ROM_AW'(1));

  p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(wb_cyc_o && wb_ack_i) |=> $stable(rom_addr));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !wb_cyc_o);

endmodule

bind rom_bus_writer rbw_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .ROM_AW (ROM_AW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rom_addr (rom_addr),
  .wb_cyc_o (wb_cyc_o),
  .wb_stb_o (wb_stb_o),
  .wb_we_o  (wb_we_o),
  .wb_sel_o (wb_sel_o),
  .wb_adr_o (wb_adr_o),
  .wb_dat_o (wb_dat_o),
  .wb_ack_i (wb_ack_i),
  .done     (done)
);

// File: tb/rom_bus_writer_test.sv
module rom_bus_writer_test;

  localparam int TBL_N = 8;
  localparam int TERM_IDX = 6;
  localparam logic [47:0] TBL [TBL_N] = '{
    48'h0000_0B00_0E07,
    48'h2024_0000_0000,
    48'h3018_0000_0003,
    48'hFFFE_FFFF_FFFF,   // R11: one address bit clear
    48'hFFFF_FFFF_FFFE,   // R11: one data bit clear
    48'h8010_A5A5_5A5A,
    48'hFFFF_FFFF_FFFF,   // terminator
    48'h4444_1234_5678    // must never be written
  };
  localparam int DLY [TBL_N] = '{0, 2, 1, 0, 3, 1, 0, 0};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] rom_addr;
  logic [47:0] rom_q;
  logic        cyc, stb, we, ack, done;
  logic [3:0]  sel;
  logic [15:0] adr;
  logic [31:0] dat;
  logic        ack_en = 1'b1;
  int          wait_cnt;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  rom_bus_writer uut (
    .clk(clk), .rst(rst), .start(start),
    .rom_addr(rom_addr), .rom_data(rom_q),
    .wb_cyc_o(cyc), .wb_stb_o(stb), .wb_we_o(we), .wb_sel_o(sel),
    .wb_adr_o(adr), .wb_dat_o(dat), .wb_ack_i(ack), .done(done)
  );

  // Table memory: one cycle read latency.
  always @(posedge clk)
    rom_q <= (rom_addr < 16'(TBL_N)) ? TBL[rom_addr[2:0]] : 48'hFFFF_FFFF_FFFF;

  // Slave: ack after DLY[rom_addr] wait cycles, one cycle wide.
  always @(posedge clk) begin
    if (rst) begin
      ack <= 1'b0;
      wait_cnt <= 0;
    end else if (ack) begin
      ack <= 1'b0;
      wait_cnt <= 0;
    end else if (cyc && stb && ack_en) begin
      if (wait_cnt >= DLY[rom_addr[2:0]]) ack <= 1'b1;
      else wait_cnt <= wait_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic idle_check(input string req);
    chk(!cyc && !stb && !we, req, {cyc, stb, we}, 0);
    chk(sel == 4'h0, req, sel, 0);
    chk(!done, req, done, 0);
    chk(rom_addr == 16'h0, req, rom_addr, 0);
  endtask

  task automatic walk_table(input bit mid_start);
    for (int k = 0; k < TBL_N; k++) begin
      if (TBL[k] == 48'hFFFF_FFFF_FFFF) begin
        bit saw_cyc = 1'b0;
        for (int t = 0; t < 10 && !done; t++) begin
          @(negedge clk);
          if (cyc) saw_cyc = 1'b1;
        end
        chk(done, "R8 done after terminator", done, 1);
        chk(!saw_cyc, "R8 no cycle for terminator", saw_cyc, 0);
        chk(rom_addr == 16'(k), "R7 address rests on terminator", rom_addr, k);
        break;
      end else begin
        bit got = 1'b0;
        bit steady = 1'b1;
        int cycles = 1;
        logic [15:0] a0;
        logic [31:0] d0;
        for (int t = 0; t < 50; t++) begin
          @(negedge clk);
          if (cyc) begin got = 1'b1; break; end
        end
        chk(got, "R3 write issued", got, 1);
        chk(adr == TBL[k][47:32], "R3 address field", adr, TBL[k][47:32]);
        chk(dat == TBL[k][31:0], "R3 data field", dat, TBL[k][31:0]);
        chk(sel == 4'hF && we, "R4 lanes and we", {sel, we}, 5'h1F);
        chk(rom_addr == 16'(k), "R7 address during write", rom_addr, k);
        a0 = adr;
        d0 = dat;
        forever begin
          @(negedge clk);
          start = mid_start && (k == 2) && (cycles == 1);
          if (!cyc) break;
          cycles++;
          if (adr != a0 || dat != d0) steady = 1'b0;
        end
        start = 1'b0;
        chk(steady, "R5 fields stable", steady, 1);
        chk(cycles == DLY[k] + 2, "R5 cycle length", cycles, DLY[k] + 2);
        chk(rom_addr == 16'(k + 1), "R7 step after ack", rom_addr, k + 1);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    idle_check("R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    idle_check("R1 after reset");

    // R2: no start, no activity
    begin
      bit moved = 1'b0;
      for (int t = 0; t < 20; t++) begin
        @(negedge clk);
        if (cyc || rom_addr != 0 || done) moved = 1'b1;
      end
      chk(!moved, "R2 idle without start", moved, 0);
    end

    // Main table walk, with a start pulse mid-write (R9)
    pulse_start();
    walk_table(1'b1);

    // R9: start after done is ignored
    pulse_start();
    begin
      bit moved = 1'b0;
      for (int t = 0; t < 20; t++) begin
        @(negedge clk);
        if (cyc || !done || rom_addr != 16'(TERM_IDX)) moved = 1'b1;
      end
      chk(!moved, "R9 start after done ignored", moved, 0);
    end

    // R10: no ack, the write stays open
    ack_en = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    idle_check("R12 reset clears done");
    pulse_start();
    begin
      bit held = 1'b1;
      for (int t = 0; t < 10 && !cyc; t++) @(negedge clk);
      for (int t = 0; t < 200; t++) begin
        @(negedge clk);
        if (!cyc || adr != TBL[0][47:32] || rom_addr != 0) held = 1'b0;
      end
      chk(held, "R10 write held without ack", held, 1);
    end

    // R12: reset mid-write, then replay from entry 0
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    idle_check("R12 reset mid-write");
    ack_en = 1'b1;
    pulse_start();
    walk_table(1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule